// File: doc/BRIEF.md
# Programmable I/O Cell Register Path

This block models the registered data path of a bank of programmable I/O cells. On the receive side, each pad bit may be taken straight into the input register on the global clock. It may instead be caught first by a fast capture stage on an early clock that leads the global clock, and then moved into the input register at the next global edge. The two-stage path lets the pad be sampled close to the point where data arrives, while every later stage stays on the low-skew global clock.

Each lane has one clock-enable pin. It is shared by the lane's input register and output register. Bank configuration decides which of the two registers obeys it. The enable never gates a clock: a register that ignores the pin loads on every global edge. On the transmit side, a per-lane selector chooses what reaches the pad. It can pass the output register straight through. It can time-multiplex the output register and the lane's clock-enable signal onto the pad, using the output clock as the select. It can also combine the same two signals in a 2-input AND for a fast pin-to-pin path.

Top module: `iocell_bank`

## Requirements
- R1: While `rst` is high at a global clock edge, the input register, the output register and the fast capture stage all load 0.
- R2: When `cfg_fast_cap` is 1, the input register takes, at a global edge, the value that the fast capture stage caught at the most recent early-clock rising edge. A pad change between that early edge and the global edge has no effect on it.
- R3: When `cfg_fast_cap` is 0, the input register takes the pad value present at the global edge.
- R4: When `cfg_ce_in` is 1, bit i of the input register loads only when `ce[i]` is 1 at the edge, and holds its value otherwise.
- R5: When `cfg_ce_out` is 1, bit i of the output register loads `out_data[i]` only when `ce[i]` is 1 at the edge, and holds its value otherwise.
- R6: A register whose enable is deselected (`cfg_ce_in` or `cfg_ce_out` equal to 0) loads on every global edge, whatever the value of `ce`.
- R7: With `cfg_omux` = 2'b00 (pass) or 2'b11 (reserved, treated as pass), `pad_out[i]` equals output register bit i.
- R8: With `cfg_omux` = 2'b01 (time-share), `pad_out[i]` equals output register bit i while `out_clk` equals `cfg_data_phase`, and equals `ce[i]` otherwise.
- R9: With `cfg_omux` = 2'b10 (AND), `pad_out[i]` equals output register bit i AND `ce[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global low-skew clock |
| rst | input | 1 | Synchronous active-high reset |
| early_clk | input | 1 | Early clock, leads `clk` by a fixed phase |
| out_clk | input | 1 | Output clock, the select of the time-share mux |
| cfg_fast_cap | input | 1 | 1: route input data through the fast capture stage |
| cfg_ce_in | input | 1 | 1: input register obeys `ce` |
| cfg_ce_out | input | 1 | 1: output register obeys `ce` |
| cfg_omux | input | 2 | Pad selector: 00 pass, 01 time-share, 10 AND, 11 pass |
| cfg_data_phase | input | 1 | Level of `out_clk` at which the output data is shown |
| ce | input | LANES | Per-lane shared clock enable, also the second pad signal |
| pad_in | input | LANES | Data arriving from the pads |
| out_data | input | LANES | Core data going to the output registers |
| in_q | output | LANES | Input register contents |
| pad_out | output | LANES | Data driven toward the pads |

## Verification
In the same global cycle, the `ce` pin acts as a register enable and also as the second data signal of the pad selector. The bench therefore loads known values into the output register, then sweeps every `ce` mask across all selector modes, both output-clock levels and both phase settings. Each pad bit is compared with a value computed from the register contents, the mask and the mode. The fast capture path is tested by changing the pad after the early edge and before the global edge. Under R2 the stale value must win, and under R3 the new one must win.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  typedef enum logic [1:0] {
    OMUX_PASS = 2'b00,
    OMUX_TIME = 2'b01,
    OMUX_AND  = 2'b10,
    OMUX_RSVD = 2'b11
  } omux_mode_e;

endpackage

// File: rtl/iocell_fast_cap.sv
module iocell_fast_cap #(
  parameter int W = 4
) (
  input  logic         early_clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // edge-triggered stand-in for the early-clock capture latch
  always_ff @(posedge early_clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/iocell_in_reg.sv
module iocell_in_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fast_en,
  input  logic         ce_sel,
  input  logic [W-1:0] ce,
  input  logic [W-1:0] cap,
  input  logic [W-1:0] direct,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;
  logic [W-1:0] en;

  assign nxt = fast_en ? cap : direct;
  assign en  = ce_sel ? ce : {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (en & nxt) | (~en & q);
  end

  // R4: a lane with its enable selected and low keeps its value
  a_r4_in_hold: assert property (@(posedge clk) disable iff (rst)
    (ce_sel && ce == '0) |=> $stable(q));

  // R3: direct path with enable deselected follows the pad one edge later
  a_r3_direct: assert property (@(posedge clk) disable iff (rst)
    (!fast_en && !ce_sel) |=> q == $past(direct));

endmodule

// File: rtl/iocell_out_lane.sv
module iocell_out_lane
  import iocell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_sel,
  input  logic       ce,
  input  logic       d,
  input  logic       out_clk,
  input  logic       data_phase,
  input  omux_mode_e mode,
  output logic       pad
);

  logic q;
  logic en;

  assign en = ce_sel ? ce : 1'b1;

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (en) q <= d;
  end

  always_comb begin
    unique case (mode)
      OMUX_TIME: pad = (out_clk == data_phase) ? q : ce;
      OMUX_AND:  pad = q & ce;
      default:   pad = q;
    endcase
  end

  // R5: selected and low enable holds the output register
  a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
    (ce_sel && !ce) |=> $stable(q));

  // R6: deselected enable loads every edge
  a_r6_out_load: assert property (@(posedge clk) disable iff (rst)
    !ce_sel |=> q == $past(d));

  // R9: AND mode never drives 1 while the second input is low
  a_r9_and_gate: assert property (@(posedge clk) disable iff (rst)
    (mode == OMUX_AND && !ce) |-> !pad);

  // R8: data phase of the time-share mux shows the output register
  a_r8_time_data: assert property (@(posedge clk) disable iff (rst)
    (mode == OMUX_TIME && out_clk == data_phase) |-> pad == q);

endmodule

// File: rtl/iocell_bank.sv
module iocell_bank
  import iocell_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             early_clk,
  input  logic             out_clk,
  input  logic             cfg_fast_cap,
  input  logic             cfg_ce_in,
  input  logic             cfg_ce_out,
  input  logic [1:0]       cfg_omux,
  input  logic             cfg_data_phase,
  input  logic [LANES-1:0] ce,
  input  logic [LANES-1:0] pad_in,
  input  logic [LANES-1:0] out_data,
  output logic [LANES-1:0] in_q,
  output logic [LANES-1:0] pad_out
);

  localparam int W = LANES;

  logic [W-1:0] cap_q;
  omux_mode_e   mode;

  assign mode = omux_mode_e'(cfg_omux);

  iocell_fast_cap #(.W(W)) u_cap (
    .early_clk (early_clk),
    .rst       (rst),
    .d         (pad_in),
    .q         (cap_q)
  );

  iocell_in_reg #(.W(W)) u_in (
    .clk     (clk),
    .rst     (rst),
    .fast_en (cfg_fast_cap),
    .ce_sel  (cfg_ce_in),
    .ce      (ce),
    .cap     (cap_q),
    .direct  (pad_in),
    .q       (in_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_lane
    iocell_out_lane u_out (
      .clk        (clk),
      .rst        (rst),
      .ce_sel     (cfg_ce_out),
      .ce         (ce[i]),
      .d          (out_data[i]),
      .out_clk    (out_clk),
      .data_phase (cfg_data_phase),
      .mode       (mode),
      .pad        (pad_out[i])
    );
  end

endmodule

// File: tb/iocell_bank_tb_top.sv
module iocell_bank_tb_top;

  localparam int L = 4;

  logic clk = 1'b0;
  logic early_clk = 1'b0;
  logic rst = 1'b1;
  logic out_clk = 1'b0;
  logic cfg_fast_cap = 1'b0, cfg_ce_in = 1'b0, cfg_ce_out = 1'b0;
  logic [1:0] cfg_omux = 2'b00;
  logic cfg_data_phase = 1'b1;
  logic [L-1:0] ce = '0, pad_in = '0, out_data = '0;
  logic [L-1:0] in_q, pad_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  iocell_bank #(.LANES(L)) dut_i (
    .clk(clk), .rst(rst), .early_clk(early_clk), .out_clk(out_clk),
    .cfg_fast_cap(cfg_fast_cap), .cfg_ce_in(cfg_ce_in), .cfg_ce_out(cfg_ce_out),
    .cfg_omux(cfg_omux), .cfg_data_phase(cfg_data_phase),
    .ce(ce), .pad_in(pad_in), .out_data(out_data),
    .in_q(in_q), .pad_out(pad_out)
  );

  always #5 clk = ~clk;

  // early clock rises 3 ns ahead of each global rising edge
  initial begin
    #2;
    forever begin
      early_clk = 1'b1; #5;
      early_clk = 1'b0; #5;
    end
  end

  task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_out(input logic [L-1:0] v);
    cfg_ce_out = 1'b0; cfg_omux = 2'b00; out_data = v;
    @(negedge clk);
  endtask

  task automatic load_in(input logic [L-1:0] v);
    cfg_ce_in = 1'b0; cfg_fast_cap = 1'b0; pad_in = v;
    @(negedge clk);
  endtask

  initial begin
    out_data = '1; pad_in = '1; ce = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 in_q", in_q, '0);
    chk("R1 pad_out", pad_out, '0);
    rst = 1'b0;

    // R2 / R3: pad changes after the early edge, before the global edge
    for (int f = 0; f < 2; f++) begin
      for (int v = 0; v < 16; v++) begin
        cfg_fast_cap = f[0]; cfg_ce_in = 1'b0;
        pad_in = L'(v);
        @(posedge early_clk); #1;
        pad_in = ~L'(v);
        @(negedge clk);
        if (f == 1) chk("R2 fast capture", in_q, L'(v));
        else        chk("R3 direct", in_q, ~L'(v));
      end
    end

    // R4 and R6 on the input register
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 16; v++) begin
        load_in(~L'(v));
        cfg_ce_in = 1'b1; ce = L'(m); pad_in = L'(v);
        @(negedge clk);
        chk("R4 in enable", in_q, (L'(m) & L'(v)) | (~L'(m) & ~L'(v)));
        cfg_ce_in = 1'b0; ce = '0; pad_in = L'(v);
        @(negedge clk);
        chk("R6 in deselected", in_q, L'(v));
      end
    end

    // R5 and R6 on the output register, seen through pass mode (R7)
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 16; v++) begin
        load_out(~L'(v));
        cfg_ce_out = 1'b1; ce = L'(m); out_data = L'(v);
        @(negedge clk);
        chk("R5 out enable", pad_out, (L'(m) & L'(v)) | (~L'(m) & ~L'(v)));
        cfg_ce_out = 1'b0; ce = '0;
        @(negedge clk);
        chk("R6 out deselected", pad_out, L'(v));
      end
    end

    // R7 / R8 / R9: selector sweep with the register loaded
    for (int q = 0; q < 16; q++) begin
      load_out(L'(q));
      for (int md = 0; md < 4; md++) begin
        for (int ph = 0; ph < 2; ph++) begin
          for (int oc = 0; oc < 2; oc++) begin
            for (int m = 0; m < 16; m++) begin
              logic [L-1:0] e;
              cfg_omux = 2'(md); cfg_data_phase = ph[0]; out_clk = oc[0]; ce = L'(m);
              #1;
              if (md == 1) e = (oc == ph) ? L'(q) : L'(m);
              else if (md == 2) e = L'(q) & L'(m);
              else e = L'(q);
              if (md == 1)      chk("R8 time-share", pad_out, e);
              else if (md == 2) chk("R9 and", pad_out, e);
              else              chk("R7 pass", pad_out, e);
            end
          end
        end
      end
      @(negedge clk);
    end

    // R1: reset after loading nonzero values
    load_out('1); load_in('1);
    rst = 1'b1; cfg_omux = 2'b00;
    @(negedge clk);
    chk("R1 reload in_q", in_q, '0);
    chk("R1 reload pad_out", pad_out, '0);
    // fast stage cleared too: capture during reset, read just after
    cfg_fast_cap = 1'b1;
    @(posedge early_clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 capture stage", in_q, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule